// File: doc/BRIEF.md
# Exception Priority Resolver

This block picks which exception should be serviced next. Each cycle it looks at a vector of request lines. For each line it has a pending bit, an enable bit and a priority. It reports the winning vector number, that vector's effective priority and a valid flag. The result comes from a register, so it is seen one clock after the inputs that produced it.

Vectors 1, 2 and 3 are the reset, non-maskable and hard-fault exceptions. Their priorities are fixed and negative, so they beat every programmable level. Vector 0 carries no exception and never competes.

Core exceptions 4 to 15 keep their priority bytes in a system bank. External interrupts, from vector 16 upward, keep theirs in a separate interrupt bank. A priority byte holds only its top implemented bits, and the unimplemented low bits always read back as zero. When two candidates share a priority, the lower vector number wins.

Top module: `exc_prio_resolver`

## Requirements
- R1: After reset, valid_o, vec_o and prio_o are 0 and every priority byte reads back as 0.
- R2: A vector is a candidate when its bit in pend_i and its bit in enable_i are both 1. Vector 0 is never a candidate. valid_o is 1 exactly when a candidate exists. With no candidate, vec_o and prio_o are 0.
- R3: Vectors 1, 2 and 3 have the fixed priorities -3, -2 and -1, shown on prio_o in two's complement. They win over any programmable level. Writes to vectors 0 to 3 are ignored, and those vectors read back 0.
- R4: Among candidates, the one with the numerically lowest priority wins. Programmable levels run from 0, the most urgent, to 2^PRIO_BITS-1.
- R5: Candidates with equal priority are resolved in favour of the lower vector number.
- R6: A write with wr_en_i stores only bits [7:8-PRIO_BITS] of wr_byte_i, which gives level wr_byte_i >> (8-PRIO_BITS). Writing level L shifted left by (8-PRIO_BITS) therefore sets level L. The low bits that are not implemented read back as 0 on rd_byte_o.
- R7: Vectors 4 to 15 are stored in the system bank and vectors 16 to 16+NUM_IRQ-1 in the interrupt bank. A write to one vector leaves every other vector unchanged. For a vector number at or beyond 16+NUM_IRQ, writes are ignored and reads return 0.
- R8: The outputs reflect pend_i, enable_i and the priority state, including a write made in the same cycle, one clock later. rd_byte_o follows rd_vec_i and the stored bytes combinationally.
- R9: When a programmable vector wins, prio_o equals its stored level, a value from 0 to 2^PRIO_BITS-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | 16+NUM_IRQ | Pending bit per vector |
| enable_i | input | 16+NUM_IRQ | Enable bit per vector |
| wr_en_i | input | 1 | Priority byte write strobe |
| wr_vec_i | input | clog2(16+NUM_IRQ) | Vector whose priority byte is written |
| wr_byte_i | input | 8 | Priority byte to write |
| rd_vec_i | input | clog2(16+NUM_IRQ) | Vector whose priority byte is read |
| rd_byte_o | output | 8 | Stored priority byte, low bits zero |
| valid_o | output | 1 | A candidate exists |
| vec_o | output | clog2(16+NUM_IRQ) | Winning vector number |
| prio_o | output | max(PRIO_BITS,2)+1 | Winning effective priority, signed |

## Verification
The bench drives the block with several kinds of candidate set:
- **Single candidates and empty sets.** These separate the valid logic from the selection logic.
- **Pairs with different levels.** These show that the comparison is by value and not by position.
- **Pairs with equal levels.** These expose the tie rule, across both banks and within one bank.
- **Mixes of fixed and programmable vectors.** These show that the negative priorities always dominate.
- **A write landing in the same cycle as a request.** This pins down the one-clock latency.

A long run of pseudo-random requests and writes follows. Every result of that run is compared against an independent model of the two banks.

// File: rtl/exc_prio_pkg.sv
package exc_prio_pkg;
    localparam int SYS_VECS   = 16;  // core exception vectors held in the system bank
    localparam int FIXED_VECS = 4;   // vectors 0..3 are not programmable
    localparam int BYTE_W     = 8;   // width of a priority byte lane
endpackage

// File: rtl/exc_prio_bank.sv
module exc_prio_bank
    import exc_prio_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int PRIO_BITS = 4,
    parameter int LOCKED    = 0,
    localparam int IW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [IW-1:0]              wr_idx_i,
    input  logic [BYTE_W-1:0]          wr_byte_i,
    input  logic [IW-1:0]              rd_idx_i,
    output logic [BYTE_W-1:0]          rd_byte_o,
    output logic [DEPTH*PRIO_BITS-1:0] lvl_next_o
);
    localparam int SHIFT = BYTE_W - PRIO_BITS;

    logic [PRIO_BITS-1:0] lvl_q [DEPTH];
    logic [PRIO_BITS-1:0] lvl_d [DEPTH];
    logic                 unused_wr_bits;

    assign unused_wr_bits = ^wr_byte_i;

    always_comb begin
        lvl_d = lvl_q;
        if (wr_en_i && int'(wr_idx_i) >= LOCKED && int'(wr_idx_i) < DEPTH) begin
            lvl_d[wr_idx_i] = wr_byte_i[BYTE_W-1 -: PRIO_BITS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) lvl_q[i] <= '0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    always_comb begin
        rd_byte_o = '0;
        if (int'(rd_idx_i) < DEPTH) begin
            rd_byte_o = BYTE_W'(lvl_q[rd_idx_i]) << SHIFT;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
        assign lvl_next_o[g*PRIO_BITS +: PRIO_BITS] = lvl_d[g];
    end
endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick
    import exc_prio_pkg::*;
#(
    parameter int NUM_VEC   = 48,
    parameter int PRIO_BITS = 4,
    localparam int VW       = $clog2(NUM_VEC),
    localparam int OW       = ((PRIO_BITS < 2) ? 2 : PRIO_BITS) + 1
) (
    input  logic [NUM_VEC-1:0]           cand_i,
    input  logic [NUM_VEC*PRIO_BITS-1:0] lvl_i,
    output logic                         valid_o,
    output logic [VW-1:0]                vec_o,
    output logic signed [OW-1:0]         prio_o
);
    logic signed [OW-1:0] cur;

    always_comb begin
        valid_o = 1'b0;
        vec_o   = '0;
        prio_o  = '0;
        cur     = '0;
        for (int v = 1; v < NUM_VEC; v++) begin
            if (v < FIXED_VECS) begin
                cur = OW'(v - FIXED_VECS);
            end else begin
                cur = OW'($signed({1'b0, lvl_i[v*PRIO_BITS +: PRIO_BITS]}));
            end
            // strict less-than keeps the earlier (lower) vector on a tie
            if (cand_i[v] && (!valid_o || cur < prio_o)) begin
                valid_o = 1'b1;
                vec_o   = VW'(v);
                prio_o  = cur;
            end
        end
    end
endmodule

// File: rtl/exc_prio_resolver.sv
module exc_prio_resolver
    import exc_prio_pkg::*;
#(
    parameter int NUM_IRQ   = 32,
    parameter int PRIO_BITS = 4,
    localparam int NUM_VEC  = SYS_VECS + NUM_IRQ,
    localparam int VW       = $clog2(NUM_VEC),
    localparam int OW       = ((PRIO_BITS < 2) ? 2 : PRIO_BITS) + 1,
    localparam int EIW      = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_VEC-1:0]   pend_i,
    input  logic [NUM_VEC-1:0]   enable_i,
    input  logic                 wr_en_i,
    input  logic [VW-1:0]        wr_vec_i,
    input  logic [BYTE_W-1:0]    wr_byte_i,
    input  logic [VW-1:0]        rd_vec_i,
    output logic [BYTE_W-1:0]    rd_byte_o,
    output logic                 valid_o,
    output logic [VW-1:0]        vec_o,
    output logic signed [OW-1:0] prio_o
);
    typedef struct packed {
        logic                 valid;
        logic [VW-1:0]        vec;
        logic signed [OW-1:0] pri;
    } res_t;

    res_t res_d, res_q;

    logic                           sys_wr, ext_wr, ext_rd;
    logic [3:0]                     sys_wr_idx, sys_rd_idx;
    logic [EIW-1:0]                 ext_wr_idx, ext_rd_idx;
    logic [BYTE_W-1:0]              sys_rd_byte, ext_rd_byte;
    logic [SYS_VECS*PRIO_BITS-1:0]  sys_lvl;
    logic [NUM_IRQ*PRIO_BITS-1:0]   ext_lvl;
    logic                           pick_valid;
    logic [VW-1:0]                  pick_vec;
    logic signed [OW-1:0]           pick_pri;

    // address decode into the two banks
    assign sys_wr     = wr_en_i && (int'(wr_vec_i) < SYS_VECS);
    assign ext_wr     = wr_en_i && (int'(wr_vec_i) >= SYS_VECS) && (int'(wr_vec_i) < NUM_VEC);
    assign ext_rd     = (int'(rd_vec_i) >= SYS_VECS) && (int'(rd_vec_i) < NUM_VEC);
    assign sys_wr_idx = 4'(wr_vec_i);
    assign sys_rd_idx = 4'(rd_vec_i);
    assign ext_wr_idx = EIW'(wr_vec_i - VW'(SYS_VECS));
    assign ext_rd_idx = EIW'(rd_vec_i - VW'(SYS_VECS));

    exc_prio_bank #(
        .DEPTH     (SYS_VECS),
        .PRIO_BITS (PRIO_BITS),
        .LOCKED    (FIXED_VECS)
    ) u_sys_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (sys_wr),
        .wr_idx_i   (sys_wr_idx),
        .wr_byte_i  (wr_byte_i),
        .rd_idx_i   (sys_rd_idx),
        .rd_byte_o  (sys_rd_byte),
        .lvl_next_o (sys_lvl)
    );

    exc_prio_bank #(
        .DEPTH     (NUM_IRQ),
        .PRIO_BITS (PRIO_BITS),
        .LOCKED    (0)
    ) u_ext_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (ext_wr),
        .wr_idx_i   (ext_wr_idx),
        .wr_byte_i  (wr_byte_i),
        .rd_idx_i   (ext_rd_idx),
        .rd_byte_o  (ext_rd_byte),
        .lvl_next_o (ext_lvl)
    );

    always_comb begin
        rd_byte_o = '0;
        if (int'(rd_vec_i) < SYS_VECS) rd_byte_o = sys_rd_byte;
        else if (ext_rd)                rd_byte_o = ext_rd_byte;
    end

    // arbitration uses the post-write levels so a write is seen one clock later
    exc_prio_pick #(
        .NUM_VEC   (NUM_VEC),
        .PRIO_BITS (PRIO_BITS)
    ) u_pick (
        .cand_i  (pend_i & enable_i),
        .lvl_i   ({ext_lvl, sys_lvl}),
        .valid_o (pick_valid),
        .vec_o   (pick_vec),
        .prio_o  (pick_pri)
    );

    always_comb begin
        res_d       = '0;
        res_d.valid = pick_valid;
        if (pick_valid) begin
            res_d.vec = pick_vec;
            res_d.pri = pick_pri;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign valid_o = res_q.valid;
    assign vec_o   = res_q.vec;
    assign prio_o  = res_q.pri;
endmodule

// File: rtl/exc_prio_resolver_chk.sv
module exc_prio_resolver_chk #(
    parameter int NUM_IRQ   = 32,
    parameter int PRIO_BITS = 4,
    localparam int NUM_VEC  = 16 + NUM_IRQ,
    localparam int VW       = $clog2(NUM_VEC),
    localparam int OW       = ((PRIO_BITS < 2) ? 2 : PRIO_BITS) + 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_VEC-1:0]   pend_i,
    input logic [NUM_VEC-1:0]   enable_i,
    input logic                 valid_o,
    input logic [VW-1:0]        vec_o,
    input logic signed [OW-1:0] prio_o
);
    logic               alive_q;
    logic [NUM_VEC-1:0] cand_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alive_q <= 1'b0;
            cand_q  <= '0;
        end else begin
            alive_q <= 1'b1;
            cand_q  <= pend_i & enable_i;
        end
    end

    AST_VALID_ANY: assert property (@(posedge clk) disable iff (!rst_n || !alive_q)
        valid_o == (|cand_q[NUM_VEC-1:1])); // R2
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (vec_o == '0 && prio_o == '0)); // R2
    AST_WIN_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n || !alive_q)
        valid_o |-> cand_q[vec_o]); // R2
    AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n || !alive_q)
        cand_q[1] |-> (vec_o == VW'(1) && prio_o == OW'(-3))); // R3
    AST_FIXED_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && vec_o >= VW'(1) && vec_o <= VW'(3)) |->
        ((vec_o == VW'(1) && prio_o == OW'(-3)) || (vec_o == VW'(2) && prio_o == OW'(-2)) ||
         (vec_o == VW'(3) && prio_o == OW'(-1)))); // R3
    AST_FIXED_BEATS: assert property (@(posedge clk) disable iff (!rst_n || !alive_q)
        (valid_o && vec_o >= VW'(4)) |-> (cand_q[3:1] == 3'b000)); // R3
    AST_PROG_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && vec_o >= VW'(4)) |-> (prio_o >= 0)); // R9
endmodule

bind exc_prio_resolver exc_prio_resolver_chk #(
    .NUM_IRQ   (NUM_IRQ),
    .PRIO_BITS (PRIO_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_i   (pend_i),
    .enable_i (enable_i),
    .valid_o  (valid_o),
    .vec_o    (vec_o),
    .prio_o   (prio_o)
);

// File: tb/exc_prio_resolver_tb.sv
module exc_prio_resolver_tb;
    localparam int NUM_IRQ = 32;
    localparam int PB      = 4;
    localparam int NV      = 16 + NUM_IRQ;
    localparam int VW      = $clog2(NV);
    localparam int OW      = PB + 1;
    localparam int SHIFT   = 8 - PB;

    typedef struct {
        bit    valid;
        int    vec;
        int    pri;
        string tag;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NV-1:0]        pend_i = '0;
    logic [NV-1:0]        enable_i = '0;
    logic                 wr_en_i = 1'b0;
    logic [VW-1:0]        wr_vec_i = '0;
    logic [7:0]           wr_byte_i = '0;
    logic [VW-1:0]        rd_vec_i = '0;
    logic [7:0]           rd_byte_o;
    logic                 valid_o;
    logic [VW-1:0]        vec_o;
    logic signed [OW-1:0] prio_o;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   lvl_m [NV];
    exp_t exp_q [$];

    always #5 clk = ~clk;

    exc_prio_resolver #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PB)) u_dut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .enable_i(enable_i),
        .wr_en_i(wr_en_i), .wr_vec_i(wr_vec_i), .wr_byte_i(wr_byte_i),
        .rd_vec_i(rd_vec_i), .rd_byte_o(rd_byte_o),
        .valid_o(valid_o), .vec_o(vec_o), .prio_o(prio_o)
    );

    function automatic logic [NV-1:0] one(input int v);
        return NV'(1) << v;
    endfunction

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // drive one cycle of inputs, update the model, queue the expected result
    task automatic step(input logic [NV-1:0] p, input logic [NV-1:0] e, input bit we,
                        input int wv, input logic [7:0] wb, input string tag);
        exp_t it;
        int   cur;
        pend_i    = p;
        enable_i  = e;
        wr_en_i   = we;
        wr_vec_i  = VW'(wv);
        wr_byte_i = wb;
        if (we && wv >= 4 && wv < NV) lvl_m[wv] = int'(wb >> SHIFT);
        it.valid = 0; it.vec = 0; it.pri = 0; it.tag = tag;
        for (int v = 1; v < NV; v++) begin
            cur = (v < 4) ? v - 4 : lvl_m[v];
            if (p[v] && e[v] && (!it.valid || cur < it.pri)) begin
                it.valid = 1; it.vec = v; it.pri = cur;
            end
        end
        exp_q.push_back(it);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic idle(input logic [NV-1:0] p, input logic [NV-1:0] e, input string tag);
        step(p, e, 1'b0, 0, 8'h00, tag);
    endtask

    task automatic chk_rd(input int v, input string tag);
        logic [7:0] exp_b;
        exp_b = (v >= 4 && v < NV) ? 8'(lvl_m[v] << SHIFT) : 8'h00;
        rd_vec_i = VW'(v);
        #1;
        n_checks++;
        if (rd_byte_o !== exp_b) begin
            n_fail++;
            $display("FAIL %s readback vec %0d: actual %02h expected %02h", tag, v, rd_byte_o, exp_b);
        end
    endtask

    // monitor: compare the registered result just after each active edge
    initial begin
        exp_t it;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() != 0) begin
                it = exp_q.pop_front();
                n_checks++;
                if (valid_o !== it.valid || int'(vec_o) != it.vec || int'(prio_o) != it.pri) begin
                    n_fail++;
                    $display("FAIL %s: actual valid=%0b vec=%0d pri=%0d expected valid=%0b vec=%0d pri=%0d",
                             it.tag, valid_o, vec_o, int'(prio_o), it.valid, it.vec, it.pri);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual run still going expected finished");
        finish_test();
    end

    initial begin
        logic [NV-1:0] all1;
        all1 = '1;
        for (int i = 0; i < NV; i++) lvl_m[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        n_checks++;
        if (valid_o !== 1'b0 || vec_o !== '0 || prio_o !== '0) begin
            n_fail++;
            $display("FAIL R1 reset outputs: actual %0b/%0d/%0d expected 0/0/0", valid_o, vec_o, int'(prio_o));
        end
        chk_rd(5, "R1");
        chk_rd(16, "R1");
        chk_rd(NV - 1, "R1");

        // R2: empty sets, disabled lines, vector 0
        idle('0, all1, "R2 nothing pending");
        idle(all1, '0, "R2 nothing enabled");
        idle(one(0), one(0), "R2 vector 0 never wins");
        idle(one(9), one(9), "R2 single core candidate");

        // R6: byte writes keep only the high bits
        step('0, '0, 1'b1, 20, 8'h5A, "R6 write vec 20");
        chk_rd(20, "R6");
        step('0, '0, 1'b1, 5, 8'hFF, "R6 write vec 5");
        chk_rd(5, "R6");

        // R3: fixed vectors not writable; R7 out of range
        step('0, '0, 1'b1, 2, 8'hF0, "R3 write to fixed vec");
        chk_rd(2, "R3");
        step('0, '0, 1'b1, 50, 8'hF0, "R7 write out of range");
        chk_rd(50, "R7");

        // R4: lower value wins regardless of position
        idle(one(5) | one(20), all1, "R4 level 5 beats level 15");
        // R9: programmable winner reports its level
        idle(one(5), all1, "R9 level 15 reported");

        // R5: ties
        step('0, '0, 1'b1, 30, 8'h50, "R5 setup vec 30");
        idle(one(20) | one(30), all1, "R5 tie 20 vs 30");
        step('0, '0, 1'b1, 10, 8'h50, "R5 setup vec 10");
        idle(one(10) | one(20) | one(30), all1, "R5 tie across banks");
        idle(one(33) | one(35), all1, "R5 tie at level 0");

        // R3: fixed priorities dominate
        idle(one(3) | one(33), all1, "R3 hard fault beats level 0");
        idle(one(2) | one(3) | one(33), all1, "R3 nmi beats hard fault");
        idle(one(1) | one(2) | one(3), all1, "R3 reset beats all");
        idle(one(1) | one(33), one(33), "R2 disabled reset ignored");

        // R7: bank independence
        step('0, '0, 1'b1, 4, 8'h30, "R7 write vec 4");
        chk_rd(20, "R7");
        chk_rd(4, "R7");

        // R8: write in the same cycle as the request
        step('0, '0, 1'b1, 40, 8'h70, "R8 setup vec 40");
        step(one(40) | one(41), all1, 1'b1, 41, 8'h20, "R8 same-cycle write");
        idle('0, all1, "R2 back to idle");

        // R4 R5 R8: pseudo-random run
        for (int n = 0; n < 400; n++) begin
            logic [NV-1:0] p, e;
            p = NV'({$urandom, $urandom});
            e = NV'({$urandom, $urandom}) | NV'({$urandom, $urandom});
            if (($urandom % 8) != 0) p[3:1] = 3'b000;
            step(p, e, ($urandom % 2) == 1, int'($urandom % 64), 8'($urandom), "R4 R5 R8 random");
        end
        for (int v = 0; v < NV; v += 7) chk_rd(v, "R6 R7 final readback");

        idle('0, '0, "R2 final idle");
        repeat (3) @(negedge clk);
        finish_test();
    end
endmodule